// File: doc/BRIEF.md
# Shared-Level PCI Interrupt Router

This block steers eight shared, level-sensitive PCI interrupt links onto a sixteen-line legacy IRQ vector. Each link owns a byte-wide routing register, reachable through a small register port. The register holds an enable-inhibit flag and a target IRQ number. Devices on a link signal through one-cycle "raise" and "drop" pulses. The link keeps a saturating count of its current requesters, so it acts as a wired-OR level line.

An IRQ line is high whenever at least one link routes to it, has a legal and enabled setting, and has a nonzero requester count. Each output line is built from every link that currently maps to it. Because of that, reprogramming an active link makes its request leave the old IRQ and appear on the new one at the same clock edge. Two links that share an IRQ keep it high until both go idle. Devices that have no link assigned use a separate direct line that bypasses the routing logic.

All event pins and register pins are plain control pins sampled on the rising clock edge. There is no valid/ready flow control and no back-pressure: every pulse is accepted in the cycle it is presented. The state that the register port and the events update becomes visible on the outputs one clock after the sampling edge.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing register reads 0x80, `irq_out` is 0, `byp_irq` is 0 and `cnt_fault` is 0.
- R2: A write to link k (`reg_addr` = k, 0..7, selecting pins 1..8) stores the data with bits 6:4 cleared. Bit 7 is the inhibit flag and bits 3:0 are the IRQ number. `reg_rdata` shows the register chosen by `reg_addr` combinationally.
- R3: A link drives nothing while its bit 7 is set, or while its IRQ number is 0, 1, 2, 8 or 13. Only IRQs 3-7, 9-12 and 14-15 can ever be driven.
- R4: A pulse on `lnk_up[k]` adds one to the count of link k and a pulse on `lnk_dn[k]` subtracts one. For a valid link, the mapped `irq_out` bit is high exactly while the count is nonzero, starting the cycle after the edge that changed the count.
- R5: Rewriting the register of an active link moves its request. In the cycle after the write, the old IRQ bit is released (unless another link holds it) and the new IRQ bit is high if the new setting is valid.
- R6: Writing a value whose masked form equals the stored value leaves `irq_out` unchanged.
- R7: When several active, valid links map to the same IRQ, that bit stays high until the last of them has dropped to zero.
- R8: The count saturates at 2^CNT_W-1 (15 by default) and at 0. A raise at the top or a drop at zero leaves the count unchanged and pulses `cnt_fault[k]` high for one cycle, in the cycle after the offending edge.
- R9: A raise and a drop on the same link in the same cycle leave its count unchanged and raise no fault.
- R10: `byp_up` sets `byp_irq` and `byp_dn` clears it from the next cycle, with both at once holding it. The bypass line never affects `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the routing register at `reg_addr` |
| reg_addr | input | 3 | Link index 0..7 for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Routing register at `reg_addr` |
| lnk_up | input | 8 | Per-link raise pulses |
| lnk_dn | input | 8 | Per-link drop pulses |
| byp_up | input | 1 | Raise pulse for the direct line |
| byp_dn | input | 1 | Drop pulse for the direct line |
| irq_out | output | 16 | Legacy IRQ levels, bit n is IRQ n |
| byp_irq | output | 1 | Direct interrupt level |
| cnt_fault | output | 8 | Per-link one-cycle counter overflow/underflow flag |

## Verification
The properties assume that events and register writes are applied as whole-cycle pulses that are stable around the rising edge. They also assume that `reg_addr` always names an existing link. The same-value-write property additionally relies on no link event arriving in the cycle of the write, because such an event could legitimately change `irq_out`. The directed stimulus changes every input only at the falling edge and never writes in the cycle of an event when it checks that a write had no effect. It also drives counter overflow and underflow on purpose, so the fault flag is exercised rather than assumed absent.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int CFG_W   = 8;
  localparam int INH_BIT = 7;

  function automatic logic [CFG_W-1:0] cfg_clean(input logic [CFG_W-1:0] v);
    return {v[INH_BIT], 3'b000, v[3:0]};
  endfunction

  function automatic logic cfg_live(input logic [CFG_W-1:0] c, input logic [15:0] permit);
    return !c[INH_BIT] && permit[c[3:0]];
  endfunction
endpackage

// File: rtl/pirq_link.sv
module pirq_link
  import pirq_pkg::*;
#(
  parameter int          N_IRQ  = 16,
  parameter int          CNT_W  = 4,
  parameter logic [15:0] PERMIT = 16'hDEF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             up,
  input  logic             dn,
  output logic [CFG_W-1:0] cfg,
  output logic [N_IRQ-1:0] hits,
  output logic             fault
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             fault_nxt;
  logic             driving;

  always_comb begin
    cnt_nxt   = cnt;
    fault_nxt = 1'b0;
    if (up && !dn) begin
      if (cnt == CNT_MAX) fault_nxt = 1'b1;
      else                cnt_nxt   = cnt + 1'b1;
    end else if (dn && !up) begin
      if (cnt == '0) fault_nxt = 1'b1;
      else           cnt_nxt   = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= 8'h80;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      if (wr_en) cfg <= cfg_clean(wr_data);
      cnt   <= cnt_nxt;
      fault <= fault_nxt;
    end
  end

  assign driving = cfg_live(cfg, PERMIT) && (cnt != '0);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_hit
    assign hits[i] = driving && (cfg[3:0] == 4'(i));
  end
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge #(
  parameter int N_LINKS = 8,
  parameter int N_IRQ   = 16
) (
  input  logic [N_LINKS-1:0][N_IRQ-1:0] hits,
  output logic [N_IRQ-1:0]              irq
);
  always_comb begin
    irq = '0;
    for (int k = 0; k < N_LINKS; k++) irq = irq | hits[k];
  end
endmodule

// File: rtl/pirq_direct.sv
module pirq_direct (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  output logic level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          level <= 1'b0;
    else if (up && !dn)  level <= 1'b1;
    else if (dn && !up)  level <= 1'b0;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int          N_LINKS = 8,
  parameter int          N_IRQ   = 16,
  parameter int          CNT_W   = 4,
  parameter logic [15:0] PERMIT  = 16'hDEF8,
  localparam int         AW      = $clog2(N_LINKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [CFG_W-1:0]   reg_wdata,
  output logic [CFG_W-1:0]   reg_rdata,
  input  logic [N_LINKS-1:0] lnk_up,
  input  logic [N_LINKS-1:0] lnk_dn,
  input  logic               byp_up,
  input  logic               byp_dn,
  output logic [N_IRQ-1:0]   irq_out,
  output logic               byp_irq,
  output logic [N_LINKS-1:0] cnt_fault
);
  logic [N_LINKS-1:0][CFG_W-1:0] cfg_all;
  logic [N_LINKS-1:0][N_IRQ-1:0] hit_all;

  for (genvar k = 0; k < N_LINKS; k++) begin : g_link
    pirq_link #(.N_IRQ(N_IRQ), .CNT_W(CNT_W), .PERMIT(PERMIT)) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we && (reg_addr == AW'(k))),
      .wr_data (reg_wdata),
      .up      (lnk_up[k]),
      .dn      (lnk_dn[k]),
      .cfg     (cfg_all[k]),
      .hits    (hit_all[k]),
      .fault   (cnt_fault[k])
    );
  end

  pirq_merge #(.N_LINKS(N_LINKS), .N_IRQ(N_IRQ)) u_merge (
    .hits (hit_all),
    .irq  (irq_out)
  );

  pirq_direct u_direct (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (byp_up),
    .dn    (byp_dn),
    .level (byp_irq)
  );

  assign reg_rdata = cfg_all[reg_addr];
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_pkg::*;
#(
  parameter int          N_LINKS = 8,
  parameter int          N_IRQ   = 16,
  parameter logic [15:0] PERMIT  = 16'hDEF8,
  parameter int          AW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [AW-1:0]      reg_addr,
  input logic [CFG_W-1:0]   reg_wdata,
  input logic [CFG_W-1:0]   reg_rdata,
  input logic [N_LINKS-1:0] lnk_up,
  input logic [N_LINKS-1:0] lnk_dn,
  input logic               byp_up,
  input logic               byp_dn,
  input logic [N_IRQ-1:0]   irq_out,
  input logic               byp_irq,
  input logic [N_LINKS-1:0] cnt_fault
);
  // R2: unused register bits always read zero
  a_r2_rdata_clean: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:4] == 3'b000);

  // R3: reserved IRQ lines are never driven
  a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~PERMIT[N_IRQ-1:0]) == '0);

  // R6: rewriting the stored value changes nothing
  a_r6_same_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && cfg_clean(reg_wdata) == reg_rdata && lnk_up == '0 && lnk_dn == '0)
      |=> $stable(irq_out));

  // R8: a fault pulse only follows a link event
  a_r8_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fault != '0) |-> $past((lnk_up ^ lnk_dn) != '0));

  // R10: the direct line follows its raise pulse
  a_r10_bypass_up: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_up && !byp_dn) |=> byp_irq);

  // R10: the direct line follows its drop pulse
  a_r10_bypass_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_dn && !byp_up) |=> !byp_irq);

  // R4: with no events and no writes the IRQ vector holds
  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && lnk_up == '0 && lnk_dn == '0) |=> $stable(irq_out));
endmodule

bind pirq_router pirq_router_chk #(
  .N_LINKS(N_LINKS), .N_IRQ(N_IRQ), .PERMIT(PERMIT), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lnk_up(lnk_up),
  .lnk_dn(lnk_dn), .byp_up(byp_up), .byp_dn(byp_dn), .irq_out(irq_out),
  .byp_irq(byp_irq), .cnt_fault(cnt_fault)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] lnk_up = '0, lnk_dn = '0;
  logic       byp_up = 1'b0, byp_dn = 1'b0;
  logic [15:0] irq_out;
  logic       byp_irq;
  logic [7:0] cnt_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pirq_router u_pirq_router (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lnk_up(lnk_up),
    .lnk_dn(lnk_dn), .byp_up(byp_up), .byp_dn(byp_dn), .irq_out(irq_out),
    .byp_irq(byp_irq), .cnt_fault(cnt_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ev(input logic [7:0] u, input logic [7:0] d);
    @(negedge clk);
    lnk_up = u; lnk_dn = d;
    @(negedge clk);
    lnk_up = '0; lnk_dn = '0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) begin
      reg_addr = 3'(k); #1;
      check("R1 reg", reg_rdata, 8'h80);
    end
    check("R1 irq", irq_out, 0);
    check("R1 byp", byp_irq, 0);
    check("R1 fault", cnt_fault, 0);
  endtask

  task automatic t_mask;
    wr(3'd0, 8'hF5);
    reg_addr = 3'd0; #1;
    check("R2 mask", reg_rdata, 8'h85);
    wr(3'd0, 8'h05);
    reg_addr = 3'd0; #1;
    check("R2 readback", reg_rdata, 8'h05);
  endtask

  task automatic t_level;
    ev(8'h01, 8'h00); check("R4 rise", irq_out, 16'h0020);
    ev(8'h01, 8'h00); check("R4 count2", irq_out, 16'h0020);
    ev(8'h00, 8'h01); check("R4 still", irq_out, 16'h0020);
    ev(8'h00, 8'h01); check("R4 fall", irq_out, 16'h0000);
  endtask

  task automatic t_reserved;
    wr(3'd1, 8'h08);
    ev(8'h02, 8'h00); check("R3 irq8", irq_out, 0);
    wr(3'd1, 8'h83);  check("R3 inhibit", irq_out, 0);
    wr(3'd1, 8'h03);  check("R5 enable", irq_out, 16'h0008);
    ev(8'h00, 8'h02); check("R4 fall", irq_out, 0);
  endtask

  task automatic t_move;
    wr(3'd2, 8'h07);
    ev(8'h04, 8'h00); check("R5 start", irq_out, 16'h0080);
    wr(3'd2, 8'h09);  check("R5 move", irq_out, 16'h0200);
    wr(3'd2, 8'h0D);  check("R3 irq13", irq_out, 0);
    wr(3'd2, 8'h8A);  check("R3 inh", irq_out, 0);
    wr(3'd2, 8'h0A);  check("R5 back", irq_out, 16'h0400);
    ev(8'h00, 8'h04); check("R4 idle", irq_out, 0);
  endtask

  task automatic t_same;
    wr(3'd7, 8'h06);
    ev(8'h80, 8'h00); check("R6 pre", irq_out, 16'h0040);
    wr(3'd7, 8'h76);  check("R6 same", irq_out, 16'h0040);
    reg_addr = 3'd7; #1;
    check("R6 reg", reg_rdata, 8'h06);
    ev(8'h00, 8'h80); check("R6 done", irq_out, 0);
  endtask

  task automatic t_share;
    wr(3'd5, 8'h0E); wr(3'd6, 8'h0E);
    ev(8'h20, 8'h00); ev(8'h40, 8'h00);
    check("R7 both", irq_out, 16'h4000);
    ev(8'h00, 8'h20); check("R7 one left", irq_out, 16'h4000);
    ev(8'h00, 8'h40); check("R7 none", irq_out, 0);
  endtask

  task automatic t_sat;
    wr(3'd3, 8'h0B);
    for (int i = 0; i < 15; i++) ev(8'h08, 8'h00);
    check("R8 no fault", cnt_fault, 0);
    ev(8'h08, 8'h00); check("R8 overflow", cnt_fault, 8'h08);
    @(negedge clk);   check("R8 pulse", cnt_fault, 0);
    for (int i = 0; i < 14; i++) ev(8'h00, 8'h08);
    check("R8 held", irq_out, 16'h0800);
    ev(8'h00, 8'h08); check("R8 empty", irq_out, 0);
    ev(8'h00, 8'h08); check("R8 underflow", cnt_fault, 8'h08);
    check("R8 low", irq_out, 0);
    ev(8'h08, 8'h00); check("R8 not wrapped", irq_out, 16'h0800);
    ev(8'h00, 8'h08);
  endtask

  task automatic t_simul;
    wr(3'd4, 8'h0C);
    ev(8'h10, 8'h00); check("R9 pre", irq_out, 16'h1000);
    ev(8'h10, 8'h10); check("R9 hold", irq_out, 16'h1000);
    check("R9 no fault", cnt_fault, 0);
    ev(8'h00, 8'h10); check("R9 count1", irq_out, 0);
  endtask

  task automatic t_bypass;
    @(negedge clk); byp_up = 1'b1;
    @(negedge clk); byp_up = 1'b0;
    check("R10 up", byp_irq, 1); check("R10 irq", irq_out, 0);
    @(negedge clk); byp_up = 1'b1; byp_dn = 1'b1;
    @(negedge clk); byp_up = 1'b0; byp_dn = 1'b0;
    check("R10 both", byp_irq, 1);
    @(negedge clk); byp_dn = 1'b1;
    @(negedge clk); byp_dn = 1'b0;
    check("R10 dn", byp_irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_mask; t_level; t_reserved; t_move;
        t_same; t_share; t_sat; t_simul; t_bypass;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule